// File: doc/BRIEF.md
# Clearable Static Word Memory

This block is a single-clock memory of 1024 words by 4 bits. It has a write-data input, a read-data output and four active-low controls: chip select, write enable, output enable and a clear request. Instead of a three-state pin, the output carries a flag that marks when the data lines are driven. A clear command empties the whole array at one clock edge. It does this by dropping a per-word valid bit, so no sequencer walks the addresses.

Each cycle, the controls select one of five modes: deselected, clear, output disabled, read or write. Deselect takes precedence over everything. When chip select is low, a low write enable selects write whatever the clear and output-enable inputs are. A clear therefore needs write enable high. Read data and its drive flag are registered and appear one clock after the read is decoded. A busy flag marks the cycle that follows each clear edge.

Top module: `clr_sram`

## Requirements
- R1: A write stores `wdata` at `addr`. A later read of that address returns the same 4-bit value, and the 1024 words are independent of one another.
- R2: While `sel_n` is 1, no write and no clear take effect, whatever the other inputs are. `rd_en` is 0 in the following cycle.
- R3: With `sel_n`=0, `we_n`=1 and `clr_n`=0 (`oe_n` ignored), every word is cleared at that clock edge. A read decoded in any later cycle returns 0000 until the word is written again.
- R4: `busy` is 1 in exactly the cycle after each clock edge at which a clear was decoded, and 0 otherwise. A clear held for two cycles gives two busy cycles.
- R5: With `sel_n`=0, `we_n`=1, `clr_n`=1 and `oe_n`=1, `rd_en` is 0 in the next cycle and memory is unchanged.
- R6: With `sel_n`=0, `we_n`=1, `clr_n`=1 and `oe_n`=0, `rd_en` is 1 in the next cycle and `rdata` holds the addressed word.
- R7: With `sel_n`=0 and `we_n`=0, the write takes place whatever `oe_n` and `clr_n` are. No clear is started, and `rd_en` is 0 in the next cycle.
- R8: A write made in the busy cycle after a clear is kept. Any word written after a clear reads back its new value, while unwritten words stay 0000.
- R9: Whenever `rd_en` is 0, `rdata` is 0000.
- R10: `rst_n` low at a clock edge empties every word and forces `rd_en` and `busy` to 0.
- R11: When `sel_n` and `we_n` rise together right after a write, `rd_en` stays 0 and does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Active-low clear request |
| sel_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 10 | Word address |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Registered read data, 0000 when not driven |
| rd_en | output | 1 | High when `rdata` is driven |
| busy | output | 1 | High in the cycle after a clear edge |

## Verification
Clear and write can meet in two ways. In the first, both are requested in the same cycle: `clr_n` and `we_n` are low together. The bench expects the write to land and the rest of the array to keep its contents. In the second, a write is issued in the busy cycle right after a clear. The bench expects the written word to survive, and a full sweep then reads back zero everywhere else. The expected array is a bench-side copy, updated from the requirements on every write, clear and reset.

// File: rtl/clr_sram_pkg.sv
// Shared types for the clearable memory: the decoded access mode.
package clr_sram_pkg;
    typedef enum logic [2:0] {
        MODE_IDLE  = 3'd0,  // deselected
        MODE_CLEAR = 3'd1,  // empty the whole array
        MODE_HOLD  = 3'd2,  // selected, output disabled
        MODE_READ  = 3'd3,  // registered read
        MODE_WRITE = 3'd4   // store one word
    } mode_e;
endpackage

// File: rtl/clr_mode_dec.sv
// Decodes the four active-low controls into one access mode per cycle.
// Assumes: deselect has top priority, and a low write enable beats clear.
module clr_mode_dec
    import clr_sram_pkg::*;
(
    input  logic clr_n,
    input  logic sel_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_go,
    output logic clr_go,
    output logic rd_go
);
    mode_e mode;

    // Priority decode of the control pins.
    always_comb begin
        if (sel_n)      mode = MODE_IDLE;
        else if (!we_n) mode = MODE_WRITE;
        else if (!clr_n) mode = MODE_CLEAR;
        else if (oe_n)  mode = MODE_HOLD;
        else            mode = MODE_READ;
    end

    // Single-bit strobes for the datapath.
    always_comb begin
        wr_go  = (mode == MODE_WRITE);
        clr_go = (mode == MODE_CLEAR);
        rd_go  = (mode == MODE_READ);
    end
endmodule

// File: rtl/clr_valid_bits.sv
// One valid flag per word. A clear drops every flag at a single edge, and a
// write raises the flag of its word. Assumes clear and write are never
// requested in the same cycle (the decoder guarantees this).
module clr_valid_bits #(
    parameter int WORDS = 1024,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_go,
    input  logic          wr_go,
    input  logic [AW-1:0] addr,
    output logic          word_ok
);
    logic [WORDS-1:0] vld;

    genvar g;
    generate
        for (g = 0; g < WORDS; g++) begin : g_flag
            // Flag for word g: reset and clear drop it, a write to g raises it.
            always_ff @(posedge clk) begin
                if (!rst_n)                          vld[g] <= 1'b0;
                else if (clr_go)                     vld[g] <= 1'b0;
                else if (wr_go && addr == AW'(g))    vld[g] <= 1'b1;
            end
        end
    endgenerate

    // Flag of the currently addressed word.
    always_comb word_ok = vld[addr];

    // R3: after a clear edge no word is valid.
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_go |=> (vld == '0));

    // R8: the written word is valid in the next cycle.
    a_r8_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> vld[$past(addr)]);
endmodule

// File: rtl/clr_word_store.sv
// Data array without reset. Validity is tracked separately, so stale
// contents are never exposed.
module clr_word_store #(
    parameter int WORDS = 1024,
    parameter int DW    = 4,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          wr_go,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_word
);
    logic [DW-1:0] mem [WORDS];

    // Store one word on a write strobe.
    always_ff @(posedge clk) begin
        if (wr_go) mem[addr] <= wdata;
    end

    // Asynchronous look-up of the addressed word.
    always_comb rd_word = mem[addr];
endmodule

// File: rtl/clr_read_port.sv
// Output register: loads the addressed word (or zero if it is not valid) on a
// read and raises the drive flag. Otherwise it parks at zero and undriven.
module clr_read_port #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_go,
    input  logic          word_ok,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] rdata,
    output logic          rd_en
);
    // Register read data and the drive flag with the same latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            rd_en <= 1'b0;
        end else if (rd_go) begin
            rdata <= word_ok ? rd_word : '0;
            rd_en <= 1'b1;
        end else begin
            rdata <= '0;
            rd_en <= 1'b0;
        end
    end

    // R9: undriven output lines are zero.
    a_r9_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

// File: rtl/clr_sram.sv
// Clearable 1024 x 4 memory. It decodes the controls, keeps data and validity
// apart, registers reads, and flags the cycle after each clear as busy.
// Assumes all inputs are synchronous to clk.
module clr_sram #(
    parameter int WORDS = 1024,
    parameter int DW    = 4,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          sel_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rd_en,
    output logic          busy
);
    logic wr_go, clr_go, rd_go, word_ok;
    logic [DW-1:0] rd_word;

    clr_mode_dec u_dec (
        .clr_n (clr_n), .sel_n (sel_n), .oe_n (oe_n), .we_n (we_n),
        .wr_go (wr_go), .clr_go (clr_go), .rd_go (rd_go)
    );

    clr_valid_bits #(.WORDS(WORDS), .AW(AW)) u_vld (
        .clk (clk), .rst_n (rst_n), .clr_go (clr_go), .wr_go (wr_go),
        .addr (addr), .word_ok (word_ok)
    );

    clr_word_store #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_mem (
        .clk (clk), .wr_go (wr_go), .addr (addr), .wdata (wdata),
        .rd_word (rd_word)
    );

    clr_read_port #(.DW(DW)) u_rd (
        .clk (clk), .rst_n (rst_n), .rd_go (rd_go), .word_ok (word_ok),
        .rd_word (rd_word), .rdata (rdata), .rd_en (rd_en)
    );

    // Busy marks the cycle after each clear edge.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= clr_go;
    end

    // R2: deselect never drives in the next cycle.
    a_r2_deselect_silent: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !rd_en);

    // R4: a clear decoded at the pins gives busy in the next cycle.
    a_r4_busy_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && we_n && !clr_n) |=> busy);

    // R4: without a clear there is no busy in the next cycle.
    a_r4_busy_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sel_n && we_n && !clr_n) |=> !busy);

    // R5: output disabled keeps the drive flag low.
    a_r5_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && we_n && clr_n && oe_n) |=> !rd_en);

    // R6: a read drives in the next cycle.
    a_r6_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && we_n && clr_n && !oe_n) |=> rd_en);

    // R7: a write keeps the output undriven.
    a_r7_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !we_n) |=> !rd_en);
endmodule

// File: tb/sim_clr_sram.sv
// Self-checking bench: sweeps the whole array with computed patterns, clears,
// and probes the clear/write overlaps.
module sim_clr_sram;
    logic       clk = 1'b0;
    logic       rst_n, clr_n, sel_n, oe_n, we_n;
    logic [9:0] addr;
    logic [3:0] wdata;
    logic [3:0] rdata;
    logic       rd_en, busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [3:0] model [1024];

    clr_sram u0 (
        .clk (clk), .rst_n (rst_n), .clr_n (clr_n), .sel_n (sel_n),
        .oe_n (oe_n), .we_n (we_n), .addr (addr), .wdata (wdata),
        .rdata (rdata), .rd_en (rd_en), .busy (busy)
    );

    always #2.5 clk = ~clk;

    function automatic logic [3:0] pat(input int a, input int k);
        return 4'((a * 5 + (a >> 4) + k) & 15);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: set inputs at the falling edge, sample 1 ns after the rise.
    task automatic step(input logic r, input logic c, input logic s,
                        input logic o, input logic w, input int a, input int d);
        @(negedge clk);
        rst_n = r; clr_n = c; sel_n = s; oe_n = o; we_n = w;
        addr = 10'(a); wdata = 4'(d);
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d, input logic o, input logic c);
        step(1, c, 0, o, 0, a, d);
        model[a] = 4'(d);
    endtask

    task automatic rd_check(input string req, input int a);
        step(1, 1, 0, 0, 1, a, 0);
        check(req, {27'd0, rd_en, rdata}, {27'd1, model[a]});
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = 4'd0;
        rst_n = 0; clr_n = 1; sel_n = 1; oe_n = 1; we_n = 1; addr = '0; wdata = '0;
        repeat (3) step(0, 1, 1, 1, 1, 0, 0);
        check("R10 rd_en after reset", rd_en, 0);
        check("R10 busy after reset", busy, 0);
        rd_check("R10 empty after reset", 0);
        rd_check("R10 empty after reset", 1023);

        // R1/R7: fill with a pattern, varying oe_n and clr_n during writes.
        for (int a = 0; a < 1024; a++) begin
            wr(a, pat(a, 0), 1'(a & 1), 1'((a >> 1) & 1));
            check("R7 write leaves output undriven", rd_en, 0);
            check("R7 write with clr_n low starts no clear", busy, 0);
        end
        for (int a = 0; a < 1024; a++) rd_check("R1 R6 readback", a);

        // R5/R9: output disabled.
        step(1, 1, 0, 1, 1, 17, 0);
        check("R5 output disabled", rd_en, 0);
        check("R9 zero while undriven", rdata, 0);

        // R2: deselected write and clear have no effect.
        step(1, 1, 1, 0, 0, 5, 4'(~pat(5, 0)));
        check("R2 deselect undriven", rd_en, 0);
        step(1, 0, 1, 0, 1, 6, 0);
        check("R2 deselected clear gives no busy", busy, 0);
        rd_check("R2 deselected write ignored", 5);
        rd_check("R2 deselected clear ignored", 6);

        // R11: sel_n and we_n rise together after a write.
        wr(9, 4'hA, 0, 1);
        check("R11 write cycle undriven", rd_en, 0);
        step(1, 1, 1, 0, 1, 9, 0);
        check("R11 no pulse on joint release", rd_en, 0);
        rd_check("R11 word kept", 9);

        // R3/R4/R8: clear, then write in the busy cycle.
        step(1, 0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 1024; i++) model[i] = 4'd0;
        check("R4 busy after clear", busy, 1);
        check("R3 clear leaves output undriven", rd_en, 0);
        wr(100, 9, 0, 1);
        check("R4 busy drops", busy, 0);
        for (int a = 0; a < 1024; a++) rd_check("R3 R8 sweep after clear", a);

        // R8: writes after clear at both ends.
        wr(0, 7, 1, 1);
        wr(1023, 12, 0, 1);
        rd_check("R8 write after clear low end", 0);
        rd_check("R8 write after clear high end", 1023);
        rd_check("R8 neighbour stays zero", 1);

        // R4: clear held two cycles.
        step(1, 0, 0, 1, 1, 0, 0);
        step(1, 0, 0, 1, 1, 0, 0);
        for (int i = 0; i < 1024; i++) model[i] = 4'd0;
        check("R4 busy second clear cycle", busy, 1);
        step(1, 1, 0, 1, 1, 0, 0);
        check("R4 busy ends", busy, 0);
        rd_check("R3 held clear empties", 0);

        // R10: reset empties written data.
        for (int a = 0; a < 16; a++) wr(a, pat(a, 3), 0, 1);
        step(1, 1, 0, 0, 1, 3, 0);
        step(0, 1, 0, 0, 1, 3, 0);
        for (int i = 0; i < 1024; i++) model[i] = 4'd0;
        check("R10 reset drops drive", rd_en, 0);
        for (int a = 0; a < 16; a++) rd_check("R10 empty after reset", a);

        finish_run();
    end
endmodule